// File: doc/BRIEF.md
# Phase-Accumulator PWM Generator with Committed Settings

This block produces up to four independent pulse-width-modulated outputs. Each channel runs a phase accumulator that adds a programmable step every clock, modulo 2^STEP_W. The output frequency is therefore f_clk × step / 2^STEP_W. The duty cycle comes from comparing the top eight bits of the accumulator against an 8-bit off-threshold, so a larger threshold gives a shorter high time. Software programs each channel through one 32-bit control word on a plain read/write register port. The channels are 0x400 bytes apart.

Values written to the step and threshold fields go to a staging copy. They reach the running waveform only when software sets the commit-request bit. The request is served at the next accumulator wrap while the channel runs, or at once while it does not. The hardware then clears the request bit. A channel produces pulses only after a commit has been served since it was last switched off, so software commits first and enables afterwards. Apart from the self-clearing request bit, every bit reads back exactly as written, which lets software save and restore the whole word.

Top module: `accpwm_top`

## Requirements
- R1: After reset every control word reads as zero, every output is low, and the running step and threshold are zero.
- R2: A read returns the addressed control word on bus_rdata one cycle after the address is presented. Every bit except bit 30 reads back exactly as last written, including bits the channel does not use.
- R3: The channel index is address bits 11:10. A write whose address bits 9:0 are not zero, or whose index is not below NUM_CH, changes no control word, and a read of such an address returns zero.
- R4: Bit 30 is the commit request. On a channel that is not running, it copies the staged step (bits 8 upward, STEP_W wide) and the staged threshold (bits 7:0) into the running settings at the next clock edge, and bit 30 then reads 0.
- R5: Bit 31 is the enable. A channel runs only while bit 31 is 1 and a commit has been served since reset or since the last write that changed bit 31 from 1 to 0. Otherwise its output stays low.
- R6: While a channel runs, its accumulator adds the running step modulo 2^STEP_W each clock. The output in cycle n+1 is 1 exactly when the top 8 accumulator bits in cycle n are greater than the running threshold.
- R7: While a channel runs, new staged values change nothing until bit 30 is set. The copy then happens on the clock edge where the accumulator wraps.
- R8: While a channel does not run, its accumulator is held at zero, so each new run starts at phase zero.
- R9: Channels are independent: a write to one channel leaves every other channel's word and waveform unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for bus_addr |
| pwm_out | output | NUM_CH | Registered PWM outputs, one per channel |

## Verification
A write lands in the control word at the clock edge that samples it. A commit on an idle channel moves the settings at the following edge, so the first pulse can appear two edges later. The waveform output always reflects the accumulator one edge earlier, and read data follows the address by one edge. The bench reference model steps once per rising edge with the same ordering: served commit, then the write, then the registered outputs. Outputs are compared on the falling edge after each rising edge, which keeps every comparison aligned to the cycle its result is due.

// File: rtl/accpwm_pkg.sv
package accpwm_pkg;
  localparam int EN_BIT   = 31;
  localparam int REQ_BIT  = 30;
  localparam int STEP_LSB = 8;
  localparam int THR_W    = 8;
  localparam int MAX_CH   = 4;
  localparam int SEL_W    = 2;
  localparam int OFS_W    = 10;
endpackage

// File: rtl/accpwm_regdec.sv
module accpwm_regdec
  import accpwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic [NUM_CH-1:0] wr_sel,
  output logic [SEL_W-1:0]  idx,
  output logic              hit
);
  logic ofs_zero;
  logic upper_zero;

  assign ofs_zero = (addr[OFS_W-1:0] == '0);
  assign idx      = addr[OFS_W +: SEL_W];

  generate
    if (ADDR_W > OFS_W + SEL_W) begin : g_upper
      assign upper_zero = (addr[ADDR_W-1:OFS_W+SEL_W] == '0);
    end else begin : g_noupper
      assign upper_zero = 1'b1;
    end
  endgenerate

  assign hit = ofs_zero & upper_zero & (int'(idx) < NUM_CH);

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      wr_sel[i] = wr & hit & (int'(idx) == i);
    end
  end
endmodule

// File: rtl/accpwm_channel.sv
module accpwm_channel
  import accpwm_pkg::*;
#(
  parameter int STEP_W = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr,
  input  logic [31:0] wdata,
  output logic [31:0] ctrl,
  output logic        pwm
);
  localparam int SUM_W = STEP_W + 1;

  logic [31:0]       ctrl_q;
  logic [STEP_W-1:0] step_run;
  logic [STEP_W-1:0] acc_q;
  logic [THR_W-1:0]  thr_run;
  logic              armed_q;
  logic              pwm_q;
  logic              running;
  logic [SUM_W-1:0]  sum;
  logic              wrap;
  logic              commit;
  logic              off_write;

  initial assert (STEP_W >= THR_W && STEP_W <= 22);

  assign running   = ctrl_q[EN_BIT] & armed_q;
  assign sum       = {1'b0, acc_q} + {1'b0, step_run};
  assign wrap      = running & sum[STEP_W];
  assign commit    = ctrl_q[REQ_BIT] & (~running | wrap);
  assign off_write = wr & ctrl_q[EN_BIT] & ~wdata[EN_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      step_run <= '0;
      thr_run  <= '0;
      armed_q  <= 1'b0;
      acc_q    <= '0;
      pwm_q    <= 1'b0;
    end else begin
      if (wr) begin
        ctrl_q <= wdata;
      end else if (commit) begin
        ctrl_q[REQ_BIT] <= 1'b0;
      end
      if (commit) begin
        step_run <= ctrl_q[STEP_LSB +: STEP_W];
        thr_run  <= ctrl_q[THR_W-1:0];
      end
      if (off_write) begin
        armed_q <= 1'b0;
      end else if (commit) begin
        armed_q <= 1'b1;
      end
      acc_q <= running ? sum[STEP_W-1:0] : '0;
      pwm_q <= running & (acc_q[STEP_W-1 -: THR_W] > thr_run);
    end
  end

  assign ctrl = ctrl_q;
  assign pwm  = pwm_q;

  // R4
  req_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (commit && !wr) |=> !ctrl_q[REQ_BIT]);

  // R7
  run_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !commit |=> ($stable(step_run) && $stable(thr_run)));

  // R5
  off_low_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[EN_BIT] |=> !pwm_q);

  // R8
  acc_park_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[EN_BIT] |=> (acc_q == '0));
endmodule

// File: rtl/accpwm_top.sv
module accpwm_top
  import accpwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int STEP_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  logic [NUM_CH-1:0] wr_sel;
  logic [SEL_W-1:0]  rd_idx;
  logic              rd_hit;
  logic [31:0]       ctrl_all [MAX_CH];
  logic [31:0]       rdata_q;

  initial assert (NUM_CH >= 1 && NUM_CH <= MAX_CH && ADDR_W >= OFS_W + SEL_W);

  accpwm_regdec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .addr   (bus_addr),
    .wr     (bus_wr),
    .wr_sel (wr_sel),
    .idx    (rd_idx),
    .hit    (rd_hit)
  );

  generate
    for (genvar c = 0; c < MAX_CH; c++) begin : g_ch
      if (c < NUM_CH) begin : g_used
        accpwm_channel #(.STEP_W(STEP_W)) u_ch (
          .clk   (clk),
          .rst   (rst),
          .wr    (wr_sel[c]),
          .wdata (bus_wdata),
          .ctrl  (ctrl_all[c]),
          .pwm   (pwm_out[c])
        );
      end else begin : g_unused
        assign ctrl_all[c] = '0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rd_hit ? ctrl_all[rd_idx] : '0;
    end
  end

  assign bus_rdata = rdata_q;

  // R3
  wr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_sel));

  // R3
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> (bus_rdata == 32'h0));
endmodule

// File: tb/sim_accpwm_top.sv
module sim_accpwm_top;
  localparam int NCH = 3;
  localparam int SW  = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] pwm_out;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit started = 1'b0;
  string cur_req = "R1";

  logic [31:0] m_ctrl [NCH];
  logic [15:0] m_step [NCH];
  logic [15:0] m_acc  [NCH];
  logic [7:0]  m_thr  [NCH];
  bit          m_arm  [NCH];
  logic [NCH-1:0] m_pwm;
  logic [31:0] m_rd;

  always #2 clk = ~clk;

  accpwm_top #(.NUM_CH(NCH), .STEP_W(SW), .ADDR_W(12)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  // reference model, one step per rising edge
  always @(posedge clk) begin
    int sel;
    bit ok;
    bit run;
    bit wrp;
    bit cmt;
    int unsigned s;
    started = 1'b1;
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        m_ctrl[c] = '0; m_step[c] = '0; m_acc[c] = '0; m_thr[c] = '0; m_arm[c] = 0;
      end
      m_pwm = '0;
      m_rd  = '0;
    end else begin
      sel = int'(bus_addr[11:10]);
      ok  = (bus_addr[9:0] == 10'd0) && (sel < NCH);
      m_rd = ok ? m_ctrl[sel] : 32'h0;
      for (int c = 0; c < NCH; c++) begin
        run = m_ctrl[c][31] && m_arm[c];
        s   = int'(m_acc[c]) + int'(m_step[c]);
        wrp = run && (s >= 65536);
        cmt = m_ctrl[c][30] && (!run || wrp);
        m_pwm[c] = run && ((m_acc[c] >> 8) > 16'(m_thr[c]));
        m_acc[c] = run ? 16'(s % 65536) : 16'h0;
        if (cmt) begin
          m_step[c] = m_ctrl[c][23:8];
          m_thr[c]  = m_ctrl[c][7:0];
          m_arm[c]  = 1;
          m_ctrl[c][30] = 1'b0;
        end
        if (bus_wr && ok && sel == c) begin
          if (m_ctrl[c][31] && !bus_wdata[31]) m_arm[c] = 0;
          m_ctrl[c] = bus_wdata;
        end
      end
    end
  end

  // comparison away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      compared++;
      if (pwm_out !== m_pwm) begin
        mismatched++;
        $display("FAIL %s pwm_out got %b expected %b at cycle %0d", cur_req, pwm_out, m_pwm, cyc);
      end
      compared++;
      if (bus_rdata !== m_rd) begin
        mismatched++;
        $display("FAIL %s bus_rdata got %h expected %h at cycle %0d", cur_req, bus_rdata, m_rd, cyc);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL watchdog got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  function automatic logic [31:0] word(bit en, bit req, logic [15:0] step, logic [7:0] thr);
    return {en, req, 6'h0, step, thr};
  endfunction

  task automatic put(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic look(input logic [11:0] a, input int n);
    @(negedge clk);
    bus_addr = a;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state of all words and outputs
    rst = 1'b0;
    look(12'h000, 3); look(12'h400, 3); look(12'h800, 3);

    // R2: readback of all bits, including unused bits 29:24
    cur_req = "R2";
    put(12'h000, 32'h3F12_3456 & ~32'h4000_0000);
    look(12'h000, 4);
    put(12'h000, 32'h0000_0000);
    look(12'h000, 2);

    // R3: misaligned offset and out-of-range channel are ignored
    cur_req = "R3";
    put(12'h004, 32'h1234_5678);
    put(12'hC00, 32'h8765_4321);
    look(12'h000, 3); look(12'hC00, 3); look(12'h004, 3);

    // R5: enable without a served commit stays low
    cur_req = "R5";
    put(12'h400, word(1, 0, 16'h0800, 8'h40));
    look(12'h400, 120);

    // R4: commit on a channel that does not run, then bit 30 reads 0
    cur_req = "R4";
    put(12'h400, word(1, 1, 16'h0800, 8'h40));
    look(12'h400, 5);

    // R6: ch0 commit first, then enable; waveform compared each cycle
    cur_req = "R6";
    put(12'h000, word(0, 1, 16'h0400, 8'h80));
    look(12'h000, 2);
    put(12'h000, word(1, 0, 16'h0400, 8'h80));
    look(12'h000, 300);

    // R9: start ch2 with its own settings alongside ch0 and ch1
    cur_req = "R9";
    put(12'h800, word(1, 1, 16'h1234, 8'h20));
    look(12'h800, 300);

    // R7: staged change without request has no effect, then request at wrap
    cur_req = "R7";
    put(12'h000, word(1, 0, 16'h0100, 8'h10));
    look(12'h000, 200);
    put(12'h000, word(1, 1, 16'h0100, 8'h10));
    look(12'h000, 700);

    // R6: threshold extremes 255 (never high) and 0
    cur_req = "R6";
    put(12'h400, word(1, 1, 16'h0C00, 8'hFF));
    look(12'h400, 200);
    put(12'h400, word(1, 1, 16'h0C00, 8'h00));
    look(12'h400, 200);

    // R8: switch off, accumulator parks, restart from phase zero
    cur_req = "R8";
    put(12'h800, word(0, 0, 16'h1234, 8'h20));
    look(12'h800, 50);
    put(12'h800, word(1, 0, 16'h1234, 8'h20));
    look(12'h800, 50);
    put(12'h800, word(1, 1, 16'h2222, 8'h60));
    look(12'h800, 300);

    // R1: reset mid-run returns to the reset state
    cur_req = "R1";
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    look(12'h000, 3); look(12'h400, 3);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule